// File: doc/BRIEF.md
# Seat-Belt Reminder Alarm Controller

This block raises a reminder alarm when a driver turns the ignition on and leaves the seat belt open for too long. It is built from two state machines that share one clock and step together. A supervisor machine follows the key and the belt. A tick-counting machine measures the grace period. The supervisor starts the counter when the key is inserted. The counter tells the supervisor through a timeout event when the grace period has run out.

The inputs are already clean and synchronous to the clock: a single-cycle key event, a belt-fastened level, and a periodic tick strobe from an external divider. The alarm output is a registered level. A driver stage outside this block uses it for a buzzer or a lamp. The two state codes and the tick count also appear on debug ports.

Top module: `belt_reminder_top`

## Requirements
- R1: With `rst_n` low at a rising clock edge, the next values are: supervisor state 0 (Off), timer state 0 (idle), tick count 0 and alarm low. The other inputs have no effect during reset.
- R2: A key event while the supervisor is in Off moves it to state 1 (Wait) at the next edge. At the same edge the timer enters state 1 (counting) with its count at 0.
- R3: While the timer is counting, each tick with the count below the limit (default 4) adds one to the count at the next edge. A cycle with no tick keeps the count unchanged.
- R4: A tick that arrives with the count equal to the limit returns the timer to idle with count 0 at the next edge. The supervisor then enters state 2 (Alarm) one edge later, if it is still in Wait.
- R5: The alarm output is high exactly while the supervisor is in Alarm. It rises and falls on the same edge as the state change.
- R6: A key event or a fastened belt while the supervisor is in Wait or Alarm returns it to Off at the next edge. The timer is forced to idle with count 0 at that edge.
- R7: When the timeout reaches the supervisor in the same cycle as a fastened belt or a key event, the return to Off wins and the alarm stays low.
- R8: Inputs without a defined transition leave the state unchanged. This covers a belt or a tick in Off, and a tick in Alarm.
- R9: When the timer is forced to idle in the same cycle as its final tick, no timeout is delivered. A later Wait period therefore starts from a fresh count and does not raise the alarm early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| key_evt | input | 1 | Single-cycle ignition key event |
| belt_on | input | 1 | High while the belt is fastened |
| tick | input | 1 | Single-cycle periodic timing strobe |
| alarm | output | 1 | Registered reminder alarm level |
| ctl_state | output | 2 | Supervisor state: 0 Off, 1 Wait, 2 Alarm |
| tmr_state | output | 1 | Timer state: 0 idle, 1 counting |
| tick_cnt | output | CNT_W (3) | Current tick count |

## Verification
The properties assume that all three inputs are known, 0 or 1, on every sampled edge once reset is released. They also assume that every input changes only between edges. They do not assume pulse widths, so the key and tick strobes may be high on consecutive cycles. The stimulus changes inputs only on the falling clock edge and never leaves an input undriven. It places the key, belt and tick events on chosen cycles so that the colliding cases arise on purpose: the final tick together with a forced stop, and a timeout together with a belt.

// File: rtl/belt_reminder_pkg.sv
// Package: shared state encodings for the seat-belt reminder.
// Assumes: the supervisor and timer codes are also exported on debug ports.
package belt_reminder_pkg;

    // Supervisor machine states
    typedef enum logic [1:0] {
        SUP_OFF   = 2'd0,
        SUP_WAIT  = 2'd1,
        SUP_ALARM = 2'd2
    } sup_state_e;

    // Tick-counting machine states
    typedef enum logic {
        TMR_IDLE  = 1'b0,
        TMR_COUNT = 1'b1
    } tmr_state_e;

endpackage

// File: rtl/belt_sup_fsm.sv
// Module: supervisor machine. It follows key and belt, starts and stops the
// timer, and holds the registered alarm.
// Assumes: timeout_evt comes from a register in the timer, so the start and
// stop outputs, which depend on the inputs, form no combinational loop.
module belt_sup_fsm
    import belt_reminder_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_evt,
    input  logic       belt_on,
    input  logic       timeout_evt,
    output sup_state_e state_q,
    output logic       alarm_q,
    output logic       start_evt,
    output logic       stop_evt
);

    sup_state_e state_d;

    // Purpose: events sent to the timer; they depend on state and inputs.
    always_comb begin
        start_evt = (state_q == SUP_OFF) && key_evt;
        stop_evt  = (state_q != SUP_OFF) && (key_evt || belt_on);
    end

    // Purpose: next state. A return to Off outranks a timeout.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SUP_OFF: begin
                if (key_evt) state_d = SUP_WAIT;
            end
            SUP_WAIT: begin
                if (key_evt || belt_on) state_d = SUP_OFF;
                else if (timeout_evt)   state_d = SUP_ALARM;
            end
            SUP_ALARM: begin
                if (key_evt || belt_on) state_d = SUP_OFF;
            end
            default: state_d = SUP_OFF;
        endcase
    end

    // Purpose: state and alarm registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SUP_OFF;
            alarm_q <= 1'b0;
        end else begin
            state_q <= state_d;
            alarm_q <= (state_d == SUP_ALARM);
        end
    end

endmodule

// File: rtl/belt_tick_timer.sv
// Module: tick-counting machine. It counts ticks after a start event and
// issues a registered one-cycle timeout when the count runs out.
// Assumes: start and stop are never high together; stop wins if they are.
module belt_tick_timer
    import belt_reminder_pkg::*;
#(
    parameter int TICK_LIMIT = 4,
    parameter int CNT_W      = $clog2(TICK_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_evt,
    input  logic             stop_evt,
    input  logic             tick,
    output tmr_state_e       state_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             timeout_q
);

    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(TICK_LIMIT);

    tmr_state_e       state_d;
    logic [CNT_W-1:0] cnt_d;
    logic             timeout_d;

    // Purpose: next state, count and timeout. Stop outranks everything.
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        timeout_d = 1'b0;
        if (stop_evt) begin
            state_d = TMR_IDLE;
            cnt_d   = '0;
        end else if (start_evt) begin
            state_d = TMR_COUNT;
            cnt_d   = '0;
        end else if (state_q == TMR_COUNT && tick) begin
            if (cnt_q == LIMIT_V) begin
                state_d   = TMR_IDLE;
                cnt_d     = '0;
                timeout_d = 1'b1;
            end else begin
                cnt_d = cnt_q + CNT_W'(1);
            end
        end
    end

    // Purpose: timer registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= TMR_IDLE;
            cnt_q     <= '0;
            timeout_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            cnt_q     <= cnt_d;
            timeout_q <= timeout_d;
        end
    end

endmodule

// File: rtl/belt_reminder_top.sv
// Module: seat-belt reminder top. It links the supervisor and the timer
// through start, stop and timeout events.
// Assumes: the inputs are clean and synchronous, and tick is a strobe.
module belt_reminder_top
    import belt_reminder_pkg::*;
#(
    parameter int TICK_LIMIT = 4,
    parameter int CNT_W      = $clog2(TICK_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_evt,
    input  logic             belt_on,
    input  logic             tick,
    output logic             alarm,
    output logic [1:0]       ctl_state,
    output logic             tmr_state,
    output logic [CNT_W-1:0] tick_cnt
);

    sup_state_e       sup_st;
    tmr_state_e       tmr_st;
    logic             start_evt;
    logic             stop_evt;
    logic             timeout_evt;
    logic             alarm_q;
    logic [CNT_W-1:0] cnt_q;

    belt_sup_fsm u_sup (
        .clk         (clk),
        .rst_n       (rst_n),
        .key_evt     (key_evt),
        .belt_on     (belt_on),
        .timeout_evt (timeout_evt),
        .state_q     (sup_st),
        .alarm_q     (alarm_q),
        .start_evt   (start_evt),
        .stop_evt    (stop_evt)
    );

    belt_tick_timer #(
        .TICK_LIMIT (TICK_LIMIT),
        .CNT_W      (CNT_W)
    ) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .tick      (tick),
        .state_q   (tmr_st),
        .cnt_q     (cnt_q),
        .timeout_q (timeout_evt)
    );

    // Purpose: present the registered values on the output ports.
    always_comb begin
        alarm     = alarm_q;
        ctl_state = sup_st;
        tmr_state = tmr_st;
        tick_cnt  = cnt_q;
    end

endmodule

// File: rtl/belt_reminder_chk.sv
// Module: property checker for the reminder, bound to the top module.
// Assumes: the inputs are known on every sampled edge after reset.
module belt_reminder_chk #(
    parameter int TICK_LIMIT = 4,
    parameter int CNT_W      = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             key_evt,
    input logic             belt_on,
    input logic             tick,
    input logic             alarm,
    input logic [1:0]       ctl_state,
    input logic             tmr_state,
    input logic [CNT_W-1:0] tick_cnt
);

    localparam logic [CNT_W-1:0] LIM = CNT_W'(TICK_LIMIT);

    AST_START_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_state == 2'd0 && key_evt) |=> (ctl_state == 2'd1 && tmr_state && tick_cnt == '0)); // R2

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_state == 2'd1 && tmr_state && tick && tick_cnt != LIM && !key_evt && !belt_on)
        |=> (tick_cnt == $past(tick_cnt) + CNT_W'(1))); // R3

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_state == 2'd1 && !tick && !key_evt && !belt_on) |=> $stable(tick_cnt)); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        tick_cnt <= LIM); // R3

    AST_TIMEOUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_state == 2'd1 && tmr_state && tick && tick_cnt == LIM && !key_evt && !belt_on)
        |=> (!tmr_state && ctl_state == 2'd1)); // R4

    AST_ALARM_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        alarm == (ctl_state == 2'd2)); // R5

    AST_RETURN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_state != 2'd0 && (key_evt || belt_on)) |=> (ctl_state == 2'd0 && !tmr_state && !alarm)); // R6

    AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_state == 2'd0 && !key_evt) |=> (ctl_state == 2'd0)); // R8

    AST_ALARM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_state == 2'd2 && !key_evt && !belt_on) |=> (ctl_state == 2'd2)); // R8

    AST_TIMER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_state != 2'd1) |-> !tmr_state); // R9

endmodule

bind belt_reminder_top belt_reminder_chk #(
    .TICK_LIMIT (TICK_LIMIT),
    .CNT_W      (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_evt   (key_evt),
    .belt_on   (belt_on),
    .tick      (tick),
    .alarm     (alarm),
    .ctl_state (ctl_state),
    .tmr_state (tmr_state),
    .tick_cnt  (tick_cnt)
);

// File: tb/belt_reminder_top_tb.sv
// Bench: scoreboard. The driver queues the expected post-edge outputs and
// the monitor compares them shortly after each rising edge.
module belt_reminder_top_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       key_evt = 1'b0;
    logic       belt_on = 1'b0;
    logic       tick = 1'b0;
    logic       alarm;
    logic [1:0] ctl_state;
    logic       tmr_state;
    logic [2:0] tick_cnt;

    typedef struct {
        int    ctl;
        int    tmr;
        int    cnt;
        int    alm;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    belt_reminder_top u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_evt   (key_evt),
        .belt_on   (belt_on),
        .tick      (tick),
        .alarm     (alarm),
        .ctl_state (ctl_state),
        .tmr_state (tmr_state),
        .tick_cnt  (tick_cnt)
    );

    // Driver: apply the inputs for one cycle and queue the expected outputs.
    task automatic step(input logic r, input logic k, input logic b, input logic t,
                        input int ec, input int et, input int en, input int ea,
                        input string req);
        exp_t e;
        @(negedge clk);
        rst_n   = r;
        key_evt = k;
        belt_on = b;
        tick    = t;
        e.ctl = ec; e.tmr = et; e.cnt = en; e.alm = ea; e.req = req;
        exp_q.push_back(e);
    endtask

    // Monitor: compare the outputs after each edge with the queued item.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (int'(ctl_state) != e.ctl || int'(tmr_state) != e.tmr ||
                    int'(tick_cnt) != e.cnt || int'(alarm) != e.alm) begin
                    n_errors++;
                    $display("FAIL %s: got ctl=%0d tmr=%0d cnt=%0d alarm=%0d, expected ctl=%0d tmr=%0d cnt=%0d alarm=%0d",
                             e.req, ctl_state, tmr_state, tick_cnt, alarm,
                             e.ctl, e.tmr, e.cnt, e.alm);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #500000;
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    // Stimulus sequence
    initial begin
        // R1: reset holds everything even with a key event present
        step(0, 1, 0, 1, 0, 0, 0, 0, "R1");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R1");
        // R8: a tick or a belt in Off changes nothing
        step(1, 0, 0, 1, 0, 0, 0, 0, "R8");
        step(1, 0, 1, 0, 0, 0, 0, 0, "R8");
        // R2: key starts the wait and the timer
        step(1, 1, 0, 0, 1, 1, 0, 0, "R2");
        step(1, 0, 0, 0, 1, 1, 0, 0, "R3");
        for (int i = 1; i <= 4; i++) begin
            step(1, 0, 0, 1, 1, 1, i, 0, "R3");
            step(1, 0, 0, 0, 1, 1, i, 0, "R3");
        end
        // R4: final tick, then the alarm one edge later
        step(1, 0, 0, 1, 1, 0, 0, 0, "R4");
        step(1, 0, 0, 0, 2, 0, 0, 1, "R5");
        step(1, 0, 0, 1, 2, 0, 0, 1, "R8");
        // R6: belt clears the alarm
        step(1, 0, 1, 0, 0, 0, 0, 0, "R6");
        // R7: timeout and belt in the same cycle
        step(1, 1, 0, 0, 1, 1, 0, 0, "R2");
        for (int i = 1; i <= 4; i++) step(1, 0, 0, 1, 1, 1, i, 0, "R3");
        step(1, 0, 0, 1, 1, 0, 0, 0, "R4");
        step(1, 0, 1, 0, 0, 0, 0, 0, "R7");
        step(1, 0, 0, 0, 0, 0, 0, 0, "R7");
        // R9: stop together with the final tick leaves no stale timeout
        step(1, 1, 0, 0, 1, 1, 0, 0, "R2");
        for (int i = 1; i <= 4; i++) step(1, 0, 0, 1, 1, 1, i, 0, "R3");
        step(1, 1, 0, 1, 0, 0, 0, 0, "R9");
        step(1, 1, 0, 0, 1, 1, 0, 0, "R9");
        step(1, 0, 0, 0, 1, 1, 0, 0, "R9");
        step(1, 0, 0, 0, 1, 1, 0, 0, "R9");
        // R6: key event in Alarm returns to Off
        for (int i = 1; i <= 4; i++) step(1, 0, 0, 1, 1, 1, i, 0, "R3");
        step(1, 0, 0, 1, 1, 0, 0, 0, "R4");
        step(1, 0, 0, 0, 2, 0, 0, 1, "R4");
        step(1, 1, 0, 0, 0, 0, 0, 0, "R6");
        // R6: key event in Wait returns to Off
        step(1, 1, 0, 0, 1, 1, 0, 0, "R2");
        step(1, 0, 0, 1, 1, 1, 1, 0, "R3");
        step(1, 1, 0, 0, 0, 0, 0, 0, "R6");
        // R1: reset in the middle of a count
        step(1, 1, 0, 0, 1, 1, 0, 0, "R2");
        step(1, 0, 0, 1, 1, 1, 1, 0, "R3");
        step(0, 0, 0, 1, 0, 0, 0, 0, "R1");
        step(1, 0, 0, 0, 0, 0, 0, 0, "R1");
        @(negedge clk);
        key_evt = 1'b0; belt_on = 1'b0; tick = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule